// File: doc/BRIEF.md
# Dual Look-Up Table with Storage Modes

This block holds two 16-bit look-up tables. Each table is addressed by four bits. A static mode input sets what the pair of tables does. The tables can act as two combinational function generators. They can act as two tapped 16-stage shift registers for capturing bursts of serial data. They can also serve as memory in several shapes: two independent 16x1 RAMs, one 16x2 RAM, one 32x1 RAM, or one 16x1 RAM with a second read-only port.

All reads are asynchronous, so an output follows its address in the same cycle. Writes and shifts take effect at the rising clock edge, and only while clock enable and write enable are both high. A serial configuration port fills both tables as one 32-bit chain. This port works while the configuration enable is high, and it overrides any write in that cycle. In function-generator mode, this port is the only way to give the tables their contents.

Top module: `cfg_lut_pair`

## Requirements
- R1: While rst_n is low, both tables are cleared to zero, so both outputs read 0 at every address.
- R2: With mode 0 (and with the unused codes 6 and 7), dout_a is table A at addr_a and dout_b is table B at addr_b. The write enable has no effect on contents.
- R3: With mode 1, a clock edge with ce and we high shifts each table up by one. din_a enters bit 0 of A and din_b enters bit 0 of B. The outputs are A at addr_a and B at addr_b, so tap k gives a delay of k+1 shifts.
- R4: With mode 2, a write stores din_a in A at addr_a and din_b in B at addr_b. The outputs read A at addr_a and B at addr_b.
- R5: With mode 3, addr_a addresses both tables. A write stores din_a in A and din_b in B. dout_a reads A and dout_b reads B at addr_a.
- R6: With mode 4, addr_hi is the fifth address bit: 0 selects A and 1 selects B. A write stores din_a in the selected table at addr_a. dout_a reads the selected table and dout_b is held at 0.
- R7: With mode 5, a write stores din_a at addr_a in both tables. dout_a reads A at addr_a and dout_b reads B at addr_b.
- R8: Reads are combinational. In the cycle of a write to the address being read, the output still shows the old bit, and the new bit appears after the edge.
- R9: While ce is low, no write and no shift occurs.
- R10: On each clock edge with cfg_en high, the 32-bit chain shifts by one. cfg_din enters A bit 0, and A bit 15 moves into B bit 0. This happens regardless of ce, we and mode, and no write happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears both tables |
| mode | input | 3 | Static function select (0 logic, 1 shift, 2 dual 16x1, 3 16x2, 4 32x1, 5 dual-port) |
| ce | input | 1 | Clock enable for writes and shifts |
| we | input | 1 | Write or shift enable |
| addr_a | input | 4 | Address of table A, or the shared and write address |
| addr_b | input | 4 | Address of table B, or the read-only address |
| addr_hi | input | 1 | Table select in 32x1 mode |
| din_a | input | 1 | Data into table A, or the common write data |
| din_b | input | 1 | Data into table B |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Configuration serial data |
| dout_a | output | 1 | First read output |
| dout_b | output | 1 | Second read output |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a write and a read of the same bit. The bench checks both outputs after it drives each cycle's inputs, and before the edge that commits the write. A correct output therefore shows the old content, and the new bit must appear in the next cycle. The second pair is a configuration shift and a write. The bench raises cfg_en at random in the middle of write traffic, with we and ce also active. The reference model then expects only the chain shift, and no write.

// File: rtl/cfg_lut_pair.sv
module cfg_lut_pair #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode,
  input  logic                     ce,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr_a,
  input  logic [$clog2(DEPTH)-1:0] addr_b,
  input  logic                     addr_hi,
  input  logic                     din_a,
  input  logic                     din_b,
  input  logic                     cfg_en,
  input  logic                     cfg_din,
  output logic                     dout_a,
  output logic                     dout_b
);
  localparam logic [2:0] M_LOGIC = 3'd0;
  localparam logic [2:0] M_SHIFT = 3'd1;
  localparam logic [2:0] M_RAM1  = 3'd2;
  localparam logic [2:0] M_RAM2W = 3'd3;
  localparam logic [2:0] M_RAM32 = 3'd4;
  localparam logic [2:0] M_DUAL  = 3'd5;

  logic [DEPTH-1:0] tbl_a, tbl_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_a <= '0;
      tbl_b <= '0;
    end else if (cfg_en) begin
      {tbl_b, tbl_a} <= {tbl_b[DEPTH-2:0], tbl_a, cfg_din};
    end else if (ce && we) begin
      case (mode)
        M_SHIFT: begin
          tbl_a <= {tbl_a[DEPTH-2:0], din_a};
          tbl_b <= {tbl_b[DEPTH-2:0], din_b};
        end
        M_RAM1: begin
          tbl_a[addr_a] <= din_a;
          tbl_b[addr_b] <= din_b;
        end
        M_RAM2W: begin
          tbl_a[addr_a] <= din_a;
          tbl_b[addr_a] <= din_b;
        end
        M_RAM32: begin
          if (addr_hi) tbl_b[addr_a] <= din_a;
          else         tbl_a[addr_a] <= din_a;
        end
        M_DUAL: begin
          tbl_a[addr_a] <= din_a;
          tbl_b[addr_a] <= din_a;
        end
        default: ;
      endcase
    end
  end

  assign dout_a = (mode == M_RAM32 && addr_hi) ? tbl_b[addr_a] : tbl_a[addr_a];
  assign dout_b = (mode == M_RAM32) ? 1'b0 :
                  (mode == M_RAM2W) ? tbl_b[addr_a] : tbl_b[addr_b];

endmodule

module cfg_lut_pair_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               mode,
  input logic                     ce,
  input logic                     we,
  input logic [$clog2(DEPTH)-1:0] addr_a,
  input logic                     din_a,
  input logic                     din_b,
  input logic                     cfg_en,
  input logic                     cfg_din,
  input logic                     dout_b,
  input logic [DEPTH-1:0]         tbl_a,
  input logic [DEPTH-1:0]         tbl_b
);
  assert_cfg_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (tbl_a[0] == $past(cfg_din)) && (tbl_b[0] == $past(tbl_a[DEPTH-1])));

  assert_hold_no_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !cfg_en) |=> ($stable(tbl_a) && $stable(tbl_b)));

  assert_logic_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !cfg_en) |=> ($stable(tbl_a) && $stable(tbl_b)));

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && ce && we && !cfg_en) |=>
      (tbl_a == {$past(tbl_a[DEPTH-2:0]), $past(din_a)}) &&
      (tbl_b == {$past(tbl_b[DEPTH-2:0]), $past(din_b)}));

  assert_dual_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && ce && we && !cfg_en) |=>
      (tbl_a[$past(addr_a)] == $past(din_a)) && (tbl_b[$past(addr_a)] == $past(din_a)));

  assert_wide_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (dout_b == 1'b0));
endmodule

bind cfg_lut_pair cfg_lut_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ce(ce), .we(we), .addr_a(addr_a),
  .din_a(din_a), .din_b(din_b), .cfg_en(cfg_en), .cfg_din(cfg_din),
  .dout_b(dout_b), .tbl_a(tbl_a), .tbl_b(tbl_b)
);

// File: tb/cfg_lut_pair_tb.sv
module cfg_lut_pair_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic ce = 0, we = 0, addr_hi = 0, din_a = 0, din_b = 0, cfg_en = 0, cfg_din = 0;
  logic [3:0] addr_a = 0, addr_b = 0;
  logic dout_a, dout_b;
  logic [15:0] ma = 0, mb = 0;
  int checks = 0, fails = 0;
  string tag_prev = "R8";

  always #4 clk = ~clk;

  cfg_lut_pair u_dut (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d: actual=%b expected=%b", tag, mode, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R2";
    endcase
  endfunction

  // R8: outputs checked before the edge that commits the cycle's write
  task automatic cycle();
    logic ea, eb;
    logic [15:0] na, nb;
    #1;
    ea = (mode == 3'd4 && addr_hi) ? mb[addr_a] : ma[addr_a];
    eb = (mode == 3'd4) ? 1'b0 : (mode == 3'd3) ? mb[addr_a] : mb[addr_b];
    chk(dout_a, ea, tag_prev);
    chk(dout_b, eb, tag_prev);
    na = ma; nb = mb;
    if (cfg_en) begin
      {nb, na} = {mb[14:0], ma, cfg_din};
    end else if (ce && we) begin
      case (mode)
        3'd1: begin na = {ma[14:0], din_a}; nb = {mb[14:0], din_b}; end
        3'd2: begin na[addr_a] = din_a; nb[addr_b] = din_b; end
        3'd3: begin na[addr_a] = din_a; nb[addr_a] = din_b; end
        3'd4: if (addr_hi) nb[addr_a] = din_a; else na[addr_a] = din_a;
        3'd5: begin na[addr_a] = din_a; nb[addr_a] = din_a; end
        default: ;
      endcase
    end
    tag_prev = cfg_en ? "R10" : (!ce ? "R9" : mode_tag(mode));
    @(posedge clk);
    ma = na; mb = nb;
    @(negedge clk);
  endtask

  task automatic drive_random(input int cfg_pct);
    addr_a = 4'($urandom); addr_b = 4'($urandom);
    addr_hi = 1'($urandom); din_a = 1'($urandom); din_b = 1'($urandom);
    ce = ($urandom % 100) < 80; we = ($urandom % 100) < 70;
    cfg_en = ($urandom % 100) < cfg_pct; cfg_din = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R1: cleared by reset
    for (int k = 0; k < 16; k += 5) begin
      addr_a = 4'(k); addr_b = 4'(15 - k); #1;
      chk(dout_a, 1'b0, "R1"); chk(dout_b, 1'b0, "R1");
    end
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m);
      for (int i = 0; i < 32; i++) begin
        drive_random(0); cfg_en = 1; cycle();
      end
      for (int i = 0; i < 250; i++) begin
        drive_random(6); cycle();
      end
    end
    // R3 directed: single one shifted through, tap k sees it after k+1 shifts
    mode = 3'd1; cfg_en = 0; ce = 1; we = 1;
    for (int i = 0; i < 16; i++) begin din_a = 0; din_b = 0; cycle(); end
    din_a = 1; din_b = 1; addr_a = 4'd15; addr_b = 4'd0; cycle();
    for (int i = 0; i < 15; i++) begin din_a = 0; din_b = 0; cycle(); end
    #1; chk(dout_a, 1'b1, "R3"); chk(dout_b, 1'b0, "R3");
    // R9 directed: ce low holds content despite we
    mode = 3'd2; ce = 0; we = 1; addr_a = 4'd3; din_a = ~ma[3];
    cycle(); cycle();
    // R8 directed: same-address write then read back
    ce = 1; addr_a = 4'd7; addr_b = 4'd7; din_a = ~ma[7]; din_b = ~mb[7];
    cycle(); cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule